// File: doc/BRIEF.md
# Stack Pointer Bounds Monitor

This block watches each update of a 16-bit stack pointer. It checks the new value against two bounds that software programs: a floor and a ceiling. If an armed monitor sees a value outside the window, it sends a single-cycle nonmaskable interrupt request to the interrupt front-end. In the same cycle it sets a sticky pending bit. It then disarms itself.

Once disarmed, the monitor ignores all further violations until software writes the ceiling register again. So each overflow must be handled and explicitly re-armed before the next one can be reported. The pending bit is separate from the arm state. It stays set until an interrupt acknowledge or an explicit clear removes it. Interrupt vectoring and the stack pointer register itself belong to the surrounding logic.

Top module: `sp_bounds_monitor`

## Requirements
- R1: Reset state:
  - `nmi_req_o` and `pend_o` are 0.
  - Both bounds are 0.
  - The monitor is disarmed, so no violation raises a request until the first ceiling write.
- R2: While armed, an update (`sp_valid_i`=1) with `sp_value_i` strictly greater than the ceiling gives a request. `nmi_req_o` is 1 for exactly the one cycle after that update's clock edge, and `pend_o` is 1 from that same cycle.
- R3: While armed, an update with `sp_value_i` strictly less than the floor gives the same request and pending set as R2.
- R4: A value equal to the floor, equal to the ceiling, or between them raises no request.
- R5: After a request, the monitor is disarmed. Later violations raise no request and leave `pend_o` unchanged, until the next ceiling write.
- R6: Register write encoding:
  - A write with `cfg_sel_i`=1 loads the ceiling and arms the monitor. Arming takes effect for updates from the next cycle on.
  - A write with `cfg_sel_i`=0 loads the floor and does not change the arm state.
- R7: Pending bit behaviour:
  - `pend_o` stays 1 until a cycle with `irq_ack_i` or `pend_clr_i` high. It is then 0 after that cycle's edge.
  - Clearing does not re-arm the monitor.
  - A new request in the same cycle as a clear leaves `pend_o` at 1.
- R8: A ceiling write in the same cycle as a violating update takes priority. That update raises no request and sets no pending bit, and the monitor is armed afterwards.
- R9: While `sp_valid_i` is 0, `sp_value_i` is ignored.
- R10: A bound write affects updates in later cycles only. An update in the same cycle as a write is compared against the previous bound value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Bound register write strobe |
| cfg_sel_i | input | 1 | Register select: 0 = floor, 1 = ceiling |
| cfg_wdata_i | input | 16 | Bound write data |
| sp_valid_i | input | 1 | Stack pointer update strobe |
| sp_value_i | input | 16 | New stack pointer value |
| irq_ack_i | input | 1 | Interrupt acknowledge, clears pending |
| pend_clr_i | input | 1 | Explicit pending clear |
| pend_o | output | 1 | Sticky overflow pending bit |
| nmi_req_o | output | 1 | One-cycle nonmaskable request pulse |

## Verification
Several kinds of update are applied, and each one separates a different faulty design:
- Values exactly on each bound, values one step beyond each bound, and values well inside the window tell inclusive comparisons from strict ones.
- Violations before the first ceiling write, after a floor-only write, and after a request has already fired show whether the arm state is really followed.
- Coincident cases tell the priority orders apart:
  - ceiling write together with a violation;
  - clear together with a new request;
  - floor write together with an update.
- Updates with the strobe low but an extreme value show whether the strobe gates the comparison.

// File: rtl/sp_guard_pkg.sv
package sp_guard_pkg;
  typedef enum logic {
    BND_FLOOR = 1'b0,
    BND_CEIL  = 1'b1
  } bnd_sel_e;
endpackage

// File: rtl/sp_bound_regs.sv
module sp_bound_regs
  import sp_guard_pkg::*;
#(
  parameter int unsigned SP_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic            sel_i,
  input  logic [SP_W-1:0] wdata_i,
  output logic [SP_W-1:0] floor_o,
  output logic [SP_W-1:0] ceil_o,
  output logic            ceil_wr_o
);
  bnd_sel_e sel;
  logic     floor_wr;

  assign sel       = bnd_sel_e'(sel_i);
  assign ceil_wr_o = we_i && (sel == BND_CEIL);
  assign floor_wr  = we_i && (sel == BND_FLOOR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      floor_o <= '0;
      ceil_o  <= '0;
    end else begin
      if (floor_wr) floor_o <= wdata_i;
      if (ceil_wr_o) ceil_o <= wdata_i;
    end
  end
endmodule

// File: rtl/sp_window_cmp.sv
module sp_window_cmp #(
  parameter int unsigned SP_W = 16
) (
  input  logic            valid_i,
  input  logic [SP_W-1:0] sp_i,
  input  logic [SP_W-1:0] floor_i,
  input  logic [SP_W-1:0] ceil_i,
  output logic            hit_o
);
  logic above, below;

  assign above = sp_i > ceil_i;
  assign below = sp_i < floor_i;
  assign hit_o = valid_i && (above || below);
endmodule

// File: rtl/sp_arm_ctrl.sv
module sp_arm_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rearm_i,
  input  logic hit_i,
  output logic fire_o,
  output logic req_o
);
  logic armed_q;

  // a re-arm in the same cycle suppresses the hit
  assign fire_o = armed_q && hit_i && !rearm_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      req_o   <= 1'b0;
    end else begin
      req_o <= fire_o;
      if (rearm_i)     armed_q <= 1'b1;
      else if (fire_o) armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sp_pend_latch.sv
module sp_pend_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_o <= 1'b0;
    else if (set_i) pend_o <= 1'b1;
    else if (clr_i) pend_o <= 1'b0;
  end
endmodule

// File: rtl/sp_bounds_monitor.sv
module sp_bounds_monitor #(
  parameter int unsigned SP_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic            cfg_sel_i,
  input  logic [SP_W-1:0] cfg_wdata_i,
  input  logic            sp_valid_i,
  input  logic [SP_W-1:0] sp_value_i,
  input  logic            irq_ack_i,
  input  logic            pend_clr_i,
  output logic            pend_o,
  output logic            nmi_req_o
);
  logic [SP_W-1:0] floor_q, ceil_q;
  logic            ceil_wr, hit, fire;

  sp_bound_regs #(.SP_W(SP_W)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .sel_i     (cfg_sel_i),
    .wdata_i   (cfg_wdata_i),
    .floor_o   (floor_q),
    .ceil_o    (ceil_q),
    .ceil_wr_o (ceil_wr)
  );

  sp_window_cmp #(.SP_W(SP_W)) i_cmp (
    .valid_i (sp_valid_i),
    .sp_i    (sp_value_i),
    .floor_i (floor_q),
    .ceil_i  (ceil_q),
    .hit_o   (hit)
  );

  sp_arm_ctrl i_arm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rearm_i (ceil_wr),
    .hit_i   (hit),
    .fire_o  (fire),
    .req_o   (nmi_req_o)
  );

  sp_pend_latch i_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (fire),
    .clr_i  (irq_ack_i || pend_clr_i),
    .pend_o (pend_o)
  );
endmodule

// File: rtl/sp_bounds_monitor_chk.sv
module sp_bounds_monitor_chk #(
  parameter int unsigned SP_W = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cfg_we_i,
  input logic            cfg_sel_i,
  input logic            sp_valid_i,
  input logic [SP_W-1:0] sp_value_i,
  input logic [SP_W-1:0] floor_q,
  input logic [SP_W-1:0] ceil_q,
  input logic            irq_ack_i,
  input logic            pend_clr_i,
  input logic            pend_o,
  input logic            nmi_req_o
);
  assert_single_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_req_o |=> !nmi_req_o);

  assert_req_sets_pend_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_req_o |-> pend_o);

  assert_only_outside_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_req_o |-> ($past(sp_value_i) > $past(ceil_q) || $past(sp_value_i) < $past(floor_q)));

  assert_pend_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !irq_ack_i && !pend_clr_i) |=> pend_o);

  assert_pend_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_o) |-> nmi_req_o);

  assert_ceil_race_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_sel_i) |=> !nmi_req_o);

  assert_no_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sp_valid_i |=> !nmi_req_o);
endmodule

bind sp_bounds_monitor sp_bounds_monitor_chk #(.SP_W(SP_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_we_i   (cfg_we_i),
  .cfg_sel_i  (cfg_sel_i),
  .sp_valid_i (sp_valid_i),
  .sp_value_i (sp_value_i),
  .floor_q    (floor_q),
  .ceil_q     (ceil_q),
  .irq_ack_i  (irq_ack_i),
  .pend_clr_i (pend_clr_i),
  .pend_o     (pend_o),
  .nmi_req_o  (nmi_req_o)
);

// File: tb/test_sp_bounds_monitor.sv
`timescale 1ns/1ps
module test_sp_bounds_monitor;
  localparam int unsigned SP_W = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [SP_W-1:0] cfg_wdata = '0;
  logic            sp_valid = 1'b0;
  logic [SP_W-1:0] sp_value = '0;
  logic            irq_ack = 1'b0, pend_clr = 1'b0;
  logic            pend, nmi_req;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // reference model state
  bit              m_armed = 1'b0, m_pend = 1'b0;
  logic [SP_W-1:0] m_floor = '0, m_ceil = '0;

  logic [1:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  sp_bounds_monitor #(.SP_W(SP_W)) i_sp_bounds_monitor (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cfg_we_i    (cfg_we),
    .cfg_sel_i   (cfg_sel),
    .cfg_wdata_i (cfg_wdata),
    .sp_valid_i  (sp_valid),
    .sp_value_i  (sp_value),
    .irq_ack_i   (irq_ack),
    .pend_clr_i  (pend_clr),
    .pend_o      (pend),
    .nmi_req_o   (nmi_req)
  );

  task automatic step(input bit we, input bit sel, input logic [SP_W-1:0] wd,
                      input bit v, input logic [SP_W-1:0] val,
                      input bit ack, input bit clr, input string tag);
    bit viol, fire, cwr;
    @(negedge clk);
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    sp_valid = v; sp_value = val; irq_ack = ack; pend_clr = clr;
    cwr  = we && sel;
    viol = v && (val > m_ceil || val < m_floor);
    fire = m_armed && viol && !cwr;
    if (fire)            m_pend = 1'b1;
    else if (ack || clr) m_pend = 1'b0;
    if (cwr)       m_armed = 1'b1;
    else if (fire) m_armed = 1'b0;
    if (we && sel)  m_ceil  = wd;
    if (we && !sel) m_floor = wd;
    exp_q.push_back({fire, m_pend});
    tag_q.push_back(tag);
  endtask

  task automatic upd(input logic [SP_W-1:0] val, input string tag);
    step(1'b0, 1'b0, '0, 1'b1, val, 1'b0, 1'b0, tag);
  endtask

  task automatic wr(input bit sel, input logic [SP_W-1:0] wd, input string tag);
    step(1'b1, sel, wd, 1'b0, '0, 1'b0, 1'b0, tag);
  endtask

  // monitor: compare one expected item per cycle, shortly after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if ({nmi_req, pend} !== e) begin
          fails++;
          $display("FAIL %s: nmi_req,pend = %b%b expected %b%b", t, nmi_req, pend, e[1], e[0]);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (nmi_req !== 1'b0 || pend !== 1'b0) begin
      fails++;
      $display("FAIL R1: reset outputs %b%b expected 00", nmi_req, pend);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R1: disarmed out of reset, bounds zero
    upd(16'h0005, "R1");
    upd(16'hFFFF, "R1");
    // R6: floor write does not arm
    wr(1'b0, 16'h1000, "R6");
    upd(16'h0800, "R6");
    // R6: ceiling write arms
    wr(1'b1, 16'h2000, "R6");
    // R4: bounds are inclusive
    upd(16'h2000, "R4");
    upd(16'h1000, "R4");
    upd(16'h1800, "R4");
    // R2: above ceiling
    upd(16'h2001, "R2");
    // R5: disarmed after firing
    upd(16'hFFFF, "R5");
    upd(16'h0000, "R5");
    // R7: pending held, then cleared by ack, not re-armed
    step(1'b0, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, "R7");
    step(1'b0, 1'b0, '0, 1'b0, '0, 1'b1, 1'b0, "R7");
    upd(16'h0001, "R7");
    // R3: below floor after re-arm
    wr(1'b1, 16'h3000, "R6");
    upd(16'h0FFF, "R3");
    // R7: explicit clear
    step(1'b0, 1'b0, '0, 1'b0, '0, 1'b0, 1'b1, "R7");
    // R7: set wins over clear
    wr(1'b1, 16'h3000, "R6");
    step(1'b0, 1'b0, '0, 1'b1, 16'h3001, 1'b0, 1'b1, "R7");
    step(1'b0, 1'b0, '0, 1'b0, '0, 1'b1, 1'b0, "R7");
    // R8: ceiling write coincident with violation
    wr(1'b1, 16'h3000, "R8");
    step(1'b1, 1'b1, 16'h3000, 1'b1, 16'hFFFF, 1'b0, 1'b0, "R8");
    upd(16'hFFFF, "R8");
    // R9: strobe low ignores value
    wr(1'b1, 16'h3000, "R9");
    step(1'b0, 1'b0, '0, 1'b0, 16'hFFFF, 1'b0, 1'b0, "R9");
    step(1'b0, 1'b0, '0, 1'b0, 16'h0000, 1'b0, 1'b0, "R9");
    upd(16'h2000, "R9");
    // R10: same-cycle floor write compares against old floor
    step(1'b1, 1'b0, 16'h0100, 1'b1, 16'h0200, 1'b1, 1'b0, "R10");
    wr(1'b1, 16'h3000, "R10");
    upd(16'h0200, "R10");
    upd(16'h00FF, "R10");
    // R10: ceiling write then value on new ceiling
    wr(1'b1, 16'h4000, "R10");
    upd(16'h4000, "R10");
    upd(16'h4001, "R2");
    step(1'b0, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, "R5");

    @(posedge clk);
    #2;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule